// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block decides which power state a processor core is in. It watches an active-low stop-clock request, an active-low deep-sleep request, a flag showing the bus clock is running, a flag showing the core voltage has been lowered, a core reset, and a snoop handshake made of a request strobe, a done flag and a bus-quiet flag. From these it steps through five states. Normal is the running state. Quick Start is a light stopped state. Snoop Service is a short visit that returns to where it came from. Deep Sleep is entered by stopping the bus clock or by raising the deep-sleep request. Deeper Sleep is Deep Sleep at a reduced voltage.

Leaving Deep Sleep takes a PLL relock delay. This delay is a parameter counted in reference-clock cycles, and a flag is high while the delay counts down. While the block is in Quick Start it also watches a group of other core inputs and raises a sticky error flag if any of them moves, or if both Deep Sleep entry methods are used at the same time.

Top module: `pss_seq`

## Requirements
- R1: While rst_ni is low and just after it is released, state_o is 0 (Normal), and err_o, relock_o and init_o are 0. State codes: 0 Normal, 1 Quick Start, 2 Snoop Service, 3 Deep Sleep, 4 Deeper Sleep.
- R2: In Normal, a low stpclk_req_ni moves the block to Quick Start at the next edge, unless a snoop is taken (R6).
- R3: Quick Start goes back to Normal only when stpclk_req_ni is high. The order of priority in Quick Start is: core reset, then snoop, then wake to Normal, then Deep Sleep entry.
- R4: In Quick Start with stpclk_req_ni low, a low bclk_run_i or a low dslp_req_ni moves the block to Deep Sleep.
- R5: In Quick Start, Deep Sleep or Deeper Sleep, if bclk_run_i and dslp_req_ni are both low in the same cycle, err_o is set at the next edge.
- R6: A high snp_req_i in Quick Start, or in Normal while halt_i is high, moves the block to Snoop Service. The block leaves Snoop Service only when snp_done_i and bus_quiet_i are both high, and then returns to the state it came from.
- R7: In Quick Start, and in a Snoop Service entered from Quick Start, any change on misc_i sets err_o at the next edge. Changes on stpclk_req_ni, cpu_rst_i and the snoop signals do not set it. err_o stays high until rst_ni is low.
- R8: A rising cpu_rst_i makes init_o high for exactly the next cycle. In Quick Start, cpu_rst_i keeps the block in Quick Start.
- R9: In Deep Sleep, relock_o is high while bclk_run_i and dslp_req_ni are both high and vlow_i is low. After LOCK_CYC consecutive cycles of this, the block enters Quick Start. Any break in the condition restarts the count.
- R10: Deeper Sleep is entered only from Deep Sleep, when vlow_i is high. It ignores any wake condition, keeps relock_o low, and returns to Deep Sleep when vlow_i goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| stpclk_req_ni | input | 1 | Stop-clock request, active low |
| dslp_req_ni | input | 1 | Deep-sleep request, active low |
| bclk_run_i | input | 1 | Bus clock is running |
| vlow_i | input | 1 | Core voltage has been lowered |
| cpu_rst_i | input | 1 | Core reset request |
| halt_i | input | 1 | Core is halted (allows snoops from Normal) |
| snp_req_i | input | 1 | Snoop request strobe |
| snp_done_i | input | 1 | Snoop has been serviced |
| bus_quiet_i | input | 1 | System bus is idle |
| misc_i | input | MISC_W | Other core inputs that must stay still in Quick Start |
| state_o | output | 3 | Current state code |
| relock_o | output | 1 | PLL relock wait is in progress |
| err_o | output | 1 | Sticky flag for illegal input activity |
| init_o | output | 1 | One-cycle core context reinitialise pulse |

## Verification
The bench counts the relock window to the exact cycle. A timer that is off by one would enter Quick Start one cycle early or one cycle late. The bench also breaks the wake condition partway through the count; a timer that does not restart would wake too soon. It raises the wake condition while the block is in Deeper Sleep. A design that let Deeper Sleep jump straight to Quick Start would skip the voltage restore. It runs snoops from both Quick Start and a halted Normal. A design with a lost return state would end in the wrong state after the snoop. Finally, it changes the exempt snoop signals inside a snoop taken from Quick Start, and changes misc_i there as well. A monitor with the wrong exemptions would either miss the error or raise a false one.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int STATE_W = 3;
  typedef enum logic [STATE_W-1:0] {
    ST_NORMAL = 3'd0,
    ST_QS     = 3'd1,
    ST_SNOOP  = 3'd2,
    ST_DEEP   = 3'd3,
    ST_DEEPER = 3'd4
  } pss_state_e;
endpackage

// File: rtl/pss_relock_timer.sv
module pss_relock_timer #(
  parameter int LOCK_CYC = 3750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pss_qs_monitor.sv
module pss_qs_monitor #(
  parameter int MISC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              watch_i,
  input  logic              dual_i,
  input  logic [MISC_W-1:0] misc_i,
  output logic              err_o
);
  logic [MISC_W-1:0] misc_q;
  logic              moved;

  assign moved = watch_i && (misc_i != misc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      misc_q <= '0;
      err_o  <= 1'b0;
    end else begin
      misc_q <= misc_i;
      err_o  <= err_o | moved | dual_i;
    end
  end
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stpclk_req_ni,
  input  logic       deep_go_i,
  input  logic       vlow_i,
  input  logic       cpu_rst_i,
  input  logic       halt_i,
  input  logic       snp_req_i,
  input  logic       snp_done_i,
  input  logic       bus_quiet_i,
  input  logic       relock_done_i,
  output pss_state_e state_o,
  output pss_state_e ret_o,
  output logic       init_o
);
  pss_state_e state_q, state_d, ret_q, ret_d;
  logic       rst_q;

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (halt_i && snp_req_i) begin
          state_d = ST_SNOOP;
          ret_d   = ST_NORMAL;
        end else if (!stpclk_req_ni) begin
          state_d = ST_QS;
        end
      end
      ST_QS: begin
        if (cpu_rst_i) begin
          state_d = ST_QS;
        end else if (snp_req_i) begin
          state_d = ST_SNOOP;
          ret_d   = ST_QS;
        end else if (stpclk_req_ni) begin
          state_d = ST_NORMAL;
        end else if (deep_go_i) begin
          state_d = ST_DEEP;
        end
      end
      ST_SNOOP:  if (snp_done_i && bus_quiet_i) state_d = ret_q;
      ST_DEEP: begin
        if (vlow_i)             state_d = ST_DEEPER;
        else if (relock_done_i) state_d = ST_QS;
      end
      ST_DEEPER: if (!vlow_i) state_d = ST_DEEP;
      default:   state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORMAL;
      ret_q   <= ST_NORMAL;
      rst_q   <= 1'b0;
      init_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      rst_q   <= cpu_rst_i;
      init_o  <= cpu_rst_i & ~rst_q;
    end
  end

  assign state_o = state_q;
  assign ret_o   = ret_q;
endmodule

// File: rtl/pss_seq.sv
module pss_seq
  import pss_pkg::*;
#(
  parameter int LOCK_CYC = 3750,
  parameter int MISC_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stpclk_req_ni,
  input  logic              dslp_req_ni,
  input  logic              bclk_run_i,
  input  logic              vlow_i,
  input  logic              cpu_rst_i,
  input  logic              halt_i,
  input  logic              snp_req_i,
  input  logic              snp_done_i,
  input  logic              bus_quiet_i,
  input  logic [MISC_W-1:0] misc_i,
  output logic [STATE_W-1:0] state_o,
  output logic              relock_o,
  output logic              err_o,
  output logic              init_o
);
  pss_state_e state, ret;
  logic relock_done, watch, dual, sleepy;

  assign sleepy   = (state == ST_QS) || (state == ST_DEEP) || (state == ST_DEEPER);
  assign dual     = sleepy && !bclk_run_i && !dslp_req_ni;
  assign watch    = (state == ST_QS) || ((state == ST_SNOOP) && (ret == ST_QS));
  assign relock_o = (state == ST_DEEP) && bclk_run_i && dslp_req_ni && !vlow_i;

  pss_relock_timer #(.LOCK_CYC(LOCK_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (relock_o),
    .done_o (relock_done)
  );

  pss_qs_monitor #(.MISC_W(MISC_W)) u_mon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .watch_i (watch),
    .dual_i  (dual),
    .misc_i  (misc_i),
    .err_o   (err_o)
  );

  pss_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .stpclk_req_ni (stpclk_req_ni),
    .deep_go_i     (!bclk_run_i || !dslp_req_ni),
    .vlow_i        (vlow_i),
    .cpu_rst_i     (cpu_rst_i),
    .halt_i        (halt_i),
    .snp_req_i     (snp_req_i),
    .snp_done_i    (snp_done_i),
    .bus_quiet_i   (bus_quiet_i),
    .relock_done_i (relock_done),
    .state_o       (state),
    .ret_o         (ret),
    .init_o        (init_o)
  );

  assign state_o = state;
endmodule

// File: rtl/pss_seq_chk.sv
module pss_seq_chk
  import pss_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               stpclk_req_ni,
  input logic               cpu_rst_i,
  input logic               vlow_i,
  input logic [STATE_W-1:0] state_o,
  input logic               relock_o,
  input logic               err_o
);
  // R3
  qs_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == ST_QS && state_o == ST_NORMAL) |-> $past(stpclk_req_ni));
  // R10
  deeper_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DEEPER && $past(state_o) != ST_DEEPER) |-> ($past(state_o) == ST_DEEP && $past(vlow_i)));
  // R9
  wake_relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == ST_DEEP && state_o == ST_QS) |-> $past(relock_o));
  // R9
  relock_where_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_o |-> state_o == ST_DEEP);
  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R8
  qs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_QS && cpu_rst_i) |=> state_o == ST_QS);
endmodule

bind pss_seq pss_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .stpclk_req_ni (stpclk_req_ni),
  .cpu_rst_i     (cpu_rst_i),
  .vlow_i        (vlow_i),
  .state_o       (state_o),
  .relock_o      (relock_o),
  .err_o         (err_o)
);

// File: tb/pss_seq_test.sv
module pss_seq_test;
  localparam int LOCK = 8;
  localparam int MW   = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic stpclk_n = 1'b1, dslp_n = 1'b1, bclk = 1'b1, vlow = 1'b0, crst = 1'b0;
  logic halt = 1'b0, sreq = 1'b0, sdone = 1'b0, squiet = 1'b0;
  logic [MW-1:0] misc = '0;
  logic [2:0] state;
  logic relock, err, init;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // bench model state
  int m_st, m_ret, m_cnt;
  bit m_err, m_rq, m_init;
  logic [MW-1:0] m_misc;

  always #4 clk = ~clk;

  pss_seq #(.LOCK_CYC(LOCK), .MISC_W(MW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .stpclk_req_ni(stpclk_n), .dslp_req_ni(dslp_n),
    .bclk_run_i(bclk), .vlow_i(vlow), .cpu_rst_i(crst), .halt_i(halt),
    .snp_req_i(sreq), .snp_done_i(sdone), .bus_quiet_i(squiet), .misc_i(misc),
    .state_o(state), .relock_o(relock), .err_o(err), .init_o(init));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit m_wake();
    return m_st == 3 && bclk && dslp_n && !vlow;
  endfunction

  function automatic int next_st(output int nret);
    int n = m_st;
    nret = m_ret;
    case (m_st)
      0: if (halt && sreq) begin n = 2; nret = 0; end else if (!stpclk_n) n = 1;
      1: if (crst) n = 1;
         else if (sreq) begin n = 2; nret = 1; end
         else if (stpclk_n) n = 0;
         else if (!bclk || !dslp_n) n = 3;
      2: if (sdone && squiet) n = m_ret;
      3: if (vlow) n = 4; else if (m_wake() && m_cnt == LOCK - 1) n = 1;
      4: if (!vlow) n = 3;
      default: n = 0;
    endcase
    return n;
  endfunction

  task automatic model_reset();
    m_st = 0; m_ret = 0; m_cnt = 0; m_err = 0; m_rq = 0; m_init = 0; m_misc = '0;
  endtask

  task automatic compare();
    chk(state == 3'(m_st), "R2 R3 R4 R6 R10 state", state, m_st);
    chk(err == m_err, "R5 R7 err", err, m_err);
    chk(relock == m_wake(), "R9 relock", relock, m_wake());
    chk(init == m_init, "R8 init", init, m_init);
  endtask

  task automatic cyc();
    int nret, nst, ncnt;
    bit nerr, sleepy, watch;
    nst = next_st(nret);
    sleepy = m_st == 1 || m_st == 3 || m_st == 4;
    watch = m_st == 1 || (m_st == 2 && m_ret == 1);
    nerr = m_err || (watch && misc != m_misc) || (sleepy && !bclk && !dslp_n);
    ncnt = m_wake() ? m_cnt + 1 : 0;
    @(posedge clk);
    #1;
    m_init = crst && !m_rq;
    m_rq = crst;
    m_misc = misc;
    m_st = nst; m_ret = nret; m_err = nerr; m_cnt = ncnt;
    compare();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    stpclk_n = 1; dslp_n = 1; bclk = 1; vlow = 0; crst = 0;
    halt = 0; sreq = 0; sdone = 0; squiet = 0; misc = '0;
    #21;
    model_reset();
    chk(state == 0 && err == 0 && relock == 0 && init == 0, "R1 reset outputs",
        {state, err, relock, init}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic n_cyc(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    do_reset();
    cyc();
    chk(state == 0, "R1 after release", state, 0);

    stpclk_n = 0; cyc();
    chk(state == 1, "R2 enter quick start", state, 1);

    crst = 1; cyc();
    chk(init == 1 && state == 1, "R8 reset in quick start", {init, state}, 5'b01001);
    crst = 0; cyc();
    chk(init == 0, "R8 single pulse", init, 0);

    dslp_n = 0; cyc();
    chk(state == 3, "R4 deep via request", state, 3);

    vlow = 1; cyc();
    chk(state == 4, "R10 enter deeper", state, 4);
    dslp_n = 1; n_cyc(10);
    chk(state == 4 && relock == 0, "R10 wake ignored in deeper", {state, relock}, 8);
    vlow = 0; cyc();
    chk(state == 3 && relock == 1, "R9 relock starts", {state, relock}, 7);
    n_cyc(3);
    bclk = 0; dslp_n = 0; dslp_n = 1; cyc();  // break: clock stopped
    bclk = 1;
    n_cyc(LOCK - 1);
    chk(state == 3, "R9 restart after break, one short", state, 3);
    cyc();
    chk(state == 1, "R9 exact relock length", state, 1);

    sreq = 1; cyc(); sreq = 0;
    chk(state == 2, "R6 snoop from quick start", state, 2);
    sdone = 1; cyc();
    chk(state == 2 && err == 0, "R7 exempt snoop signal", {state, err}, 4);
    squiet = 1; cyc(); sdone = 0; squiet = 0;
    chk(state == 1, "R6 return to quick start", state, 1);

    stpclk_n = 1; cyc();
    chk(state == 0, "R3 wake to normal", state, 0);
    halt = 1; sreq = 1; cyc(); sreq = 0; halt = 0;
    chk(state == 2, "R6 snoop from halted normal", state, 2);
    misc = 4'h3; cyc();
    chk(err == 0, "R7 misc unwatched when snoop from normal", err, 0);
    sdone = 1; squiet = 1; cyc(); sdone = 0; squiet = 0;
    chk(state == 0, "R6 return to normal", state, 0);

    stpclk_n = 0; cyc();
    sreq = 1; cyc(); sreq = 0;
    misc = 4'h5; cyc();
    chk(err == 1, "R7 misc change in snoop from quick start", err, 1);
    n_cyc(3);
    chk(err == 1, "R7 sticky", err, 1);

    do_reset();
    stpclk_n = 0; cyc();
    misc = 4'h1; cyc();
    chk(err == 1, "R7 misc change in quick start", err, 1);

    do_reset();
    stpclk_n = 0; cyc();
    bclk = 0; dslp_n = 0; cyc();
    chk(err == 1 && state == 3, "R5 dual entry", {err, state}, 11);

    for (int blk = 0; blk < 6; blk++) begin
      do_reset();
      for (int i = 0; i < 1500; i++) begin
        if ($urandom_range(0, 9) == 0) stpclk_n = ~stpclk_n;
        if ($urandom_range(0, 11) == 0) dslp_n = ~dslp_n;
        if ($urandom_range(0, 11) == 0) bclk = ~bclk;
        if ($urandom_range(0, 19) == 0) vlow = ~vlow;
        crst   = ($urandom_range(0, 29) == 0);
        halt   = ($urandom_range(0, 3) == 0);
        sreq   = ($urandom_range(0, 24) == 0);
        sdone  = ($urandom_range(0, 2) == 0);
        squiet = ($urandom_range(0, 1) == 0);
        if (blk > 2 && $urandom_range(0, 199) == 0) misc = 4'($urandom);
        cyc();
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule